// File: doc/BRIEF.md
# Fault Classification and Status Logic

This block sits beside a processor core and receives single-cycle fault events from four places: the instruction fetch path, the data access path, the vector-table read and the exception-frame push. For each event it picks the handler that must service it (hard fault, memory-management fault, bus fault or usage fault). It records the cause in two sticky status words and raises a one-cycle request for the chosen handler on the clock edge after the event.

Three handlers are configurable: memory-management, bus and usage. Any of them is escalated to a hard fault when its enable is clear or when that handler is already running. An escalation sets a dedicated forced flag in the hard-fault word.

Software reads the two status words through a small register port. Software clears bits by writing ones to them.

Top module: `fault_classifier`

## Requirements
- R1: A bus error on a vector-table read (`vec_bus_err`) raises `req_hard` on the next cycle and sets VECT, bit 1 of the hard-fault word (`reg_sel`=0).
- R2: A protection mismatch on an instruction fetch, including an execute-never fetch (`if_prot_err`), sets IERR, bit 0 of the memory-management word (`reg_sel`=1). When not escalated, it raises `req_mem` on the next cycle.
- R3: A protection mismatch on a data access (`dat_prot_err`) sets DERR, bit 1 of the memory-management word. When not escalated, it raises `req_mem`.
- R4: A protection mismatch while pushing the exception frame (`stk_prot_err`) sets MSTKE, bit 4 of the memory-management word. When not escalated, it raises `req_mem`.
- R5: A memory-management event is escalated when `mm_en` is 0 or `mm_act` is 1. In that case `req_hard` is raised instead of `req_mem`, FORCED (bit 30 of the hard-fault word) is set, and the memory-management cause bits are still set.
- R6: Instruction or data bus errors go to `req_bus`, and undefined instructions or illegal state changes go to `req_usage`. Each of these is escalated to `req_hard` with FORCED set under the same enable/active rule, using `bus_en`/`bus_act` or `use_en`/`use_act`.
- R7: Status bits stay set until a write (`reg_wr`=1) to the selected word has a 1 in that bit position. A 0 in the written data leaves the bit unchanged. A bit set by a new event in the same cycle as its clear stays set.
- R8: At most one request output is high in any cycle, with priority hard > memory-management > bus > usage. All cause bits of faults arriving in the same cycle are set.
- R9: After reset both status words read zero and all request outputs are low.
- R10: Bits other than VECT and FORCED in the hard-fault word, and other than IERR, DERR and MSTKE in the memory-management word, always read zero, even after a write of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_bus_err | input | 1 | Bus error on a vector-table read |
| if_prot_err | input | 1 | Protection mismatch on an instruction fetch |
| dat_prot_err | input | 1 | Protection mismatch on a data access |
| stk_prot_err | input | 1 | Protection mismatch during frame push |
| if_bus_err | input | 1 | Bus error on an instruction fetch |
| dat_bus_err | input | 1 | Bus error on a data access |
| undef_instr | input | 1 | Undefined instruction |
| bad_state | input | 1 | Illegal state change attempt |
| mm_en | input | 1 | Memory-management handler enabled |
| mm_act | input | 1 | Memory-management handler running |
| bus_en | input | 1 | Bus-fault handler enabled |
| bus_act | input | 1 | Bus-fault handler running |
| use_en | input | 1 | Usage-fault handler enabled |
| use_act | input | 1 | Usage-fault handler running |
| reg_sel | input | 1 | Word select: 0 hard-fault, 1 memory-management |
| reg_wr | input | 1 | Write-one-to-clear strobe |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Selected status word |
| req_hard | output | 1 | Hard-fault handler request |
| req_mem | output | 1 | Memory-management handler request |
| req_bus | output | 1 | Bus-fault handler request |
| req_usage | output | 1 | Usage-fault handler request |

## Verification
The assertions check on every cycle that at most one request is high, that a vector error is followed by a hard request, and that an escalated memory-management event produces a hard request with FORCED. They also check that IERR stays set unless a write clears it, and that unused bits stay zero. Only the bench scenarios can show the full mapping under mixed traffic. That includes the priority among simultaneous events, set-over-clear in the same cycle, and the fact that a write of zeros or a write to the other word leaves the status unchanged.

// File: rtl/fault_classifier.sv
module fault_classifier #(
  parameter int W          = 32,
  parameter int VECT_BIT   = 1,
  parameter int FORCED_BIT = 30,
  parameter int IERR_BIT   = 0,
  parameter int DERR_BIT   = 1,
  parameter int MSTKE_BIT  = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vec_bus_err,
  input  logic         if_prot_err,
  input  logic         dat_prot_err,
  input  logic         stk_prot_err,
  input  logic         if_bus_err,
  input  logic         dat_bus_err,
  input  logic         undef_instr,
  input  logic         bad_state,
  input  logic         mm_en,
  input  logic         mm_act,
  input  logic         bus_en,
  input  logic         bus_act,
  input  logic         use_en,
  input  logic         use_act,
  input  logic         reg_sel,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  output logic         req_hard,
  output logic         req_mem,
  output logic         req_bus,
  output logic         req_usage
);
  localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] HF_MASK = (ONE << VECT_BIT) | (ONE << FORCED_BIT);
  localparam logic [W-1:0] MM_MASK = (ONE << IERR_BIT) | (ONE << DERR_BIT) | (ONE << MSTKE_BIT);

  logic [W-1:0] hf_q, mm_q, hf_set, mm_set, hf_clr, mm_clr;
  logic mm_evt, bus_evt, use_evt, mm_esc, bus_esc, use_esc, forced, hard;
  logic mem_go, bus_go, use_go;

  assign mm_evt  = if_prot_err | dat_prot_err | stk_prot_err;
  assign bus_evt = if_bus_err | dat_bus_err;
  assign use_evt = undef_instr | bad_state;

  assign mm_esc  = mm_evt  & (~mm_en  | mm_act);
  assign bus_esc = bus_evt & (~bus_en | bus_act);
  assign use_esc = use_evt & (~use_en | use_act);
  assign forced  = mm_esc | bus_esc | use_esc;
  assign hard    = vec_bus_err | forced;

  assign mem_go  = mm_evt  & ~mm_esc;
  assign bus_go  = bus_evt & ~bus_esc;
  assign use_go  = use_evt & ~use_esc;

  assign hf_set = ({W{vec_bus_err}} & (ONE << VECT_BIT)) |
                  ({W{forced}}      & (ONE << FORCED_BIT));
  assign mm_set = ({W{if_prot_err}}  & (ONE << IERR_BIT)) |
                  ({W{dat_prot_err}} & (ONE << DERR_BIT)) |
                  ({W{stk_prot_err}} & (ONE << MSTKE_BIT));

  assign hf_clr = {W{reg_wr & ~reg_sel}} & reg_wdata & HF_MASK;
  assign mm_clr = {W{reg_wr &  reg_sel}} & reg_wdata & MM_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hf_q      <= '0;
      mm_q      <= '0;
      req_hard  <= 1'b0;
      req_mem   <= 1'b0;
      req_bus   <= 1'b0;
      req_usage <= 1'b0;
    end else begin
      hf_q      <= (hf_q & ~hf_clr) | hf_set;
      mm_q      <= (mm_q & ~mm_clr) | mm_set;
      req_hard  <= hard;
      req_mem   <= ~hard & mem_go;
      req_bus   <= ~hard & ~mem_go & bus_go;
      req_usage <= ~hard & ~mem_go & ~bus_go & use_go;
    end
  end

  assign reg_rdata = reg_sel ? mm_q : hf_q;
endmodule

// File: rtl/fault_classifier_chk.sv
module fault_classifier_chk #(
  parameter int W          = 32,
  parameter int VECT_BIT   = 1,
  parameter int FORCED_BIT = 30,
  parameter int IERR_BIT   = 0,
  parameter int DERR_BIT   = 1,
  parameter int MSTKE_BIT  = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         vec_bus_err,
  input logic         if_prot_err,
  input logic         dat_prot_err,
  input logic         stk_prot_err,
  input logic         mm_en,
  input logic         mm_act,
  input logic         reg_sel,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] hf_q,
  input logic [W-1:0] mm_q,
  input logic         req_hard,
  input logic         req_mem,
  input logic         req_bus,
  input logic         req_usage
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] HF_MASK = (ONE << VECT_BIT) | (ONE << FORCED_BIT);
  localparam logic [W-1:0] MM_MASK = (ONE << IERR_BIT) | (ONE << DERR_BIT) | (ONE << MSTKE_BIT);

  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_hard, req_mem, req_bus, req_usage}));

  a_r1_vect_hard: assert property (@(posedge clk) disable iff (!rst_n)
    vec_bus_err |=> (req_hard && hf_q[VECT_BIT]));

  a_r5_mm_escalate: assert property (@(posedge clk) disable iff (!rst_n)
    ((if_prot_err || dat_prot_err || stk_prot_err) && (!mm_en || mm_act))
      |=> (req_hard && !req_mem && hf_q[FORCED_BIT]));

  a_r7_ierr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_q[IERR_BIT] && !(reg_wr && reg_sel && reg_wdata[IERR_BIT])) |=> mm_q[IERR_BIT]);

  a_r2_ierr_set: assert property (@(posedge clk) disable iff (!rst_n)
    if_prot_err |=> mm_q[IERR_BIT]);

  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((hf_q & ~HF_MASK) == '0) && ((mm_q & ~MM_MASK) == '0));
endmodule

bind fault_classifier fault_classifier_chk #(
  .W(W), .VECT_BIT(VECT_BIT), .FORCED_BIT(FORCED_BIT),
  .IERR_BIT(IERR_BIT), .DERR_BIT(DERR_BIT), .MSTKE_BIT(MSTKE_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .vec_bus_err(vec_bus_err),
  .if_prot_err(if_prot_err), .dat_prot_err(dat_prot_err), .stk_prot_err(stk_prot_err),
  .mm_en(mm_en), .mm_act(mm_act), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .hf_q(hf_q), .mm_q(mm_q),
  .req_hard(req_hard), .req_mem(req_mem), .req_bus(req_bus), .req_usage(req_usage)
);

// File: tb/fault_classifier_bench.sv
module fault_classifier_bench;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  ev = '0;
  logic [5:0]  cfg = 6'b010101;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_hard, req_mem, req_bus, req_usage;

  int n_chk = 0, n_fail = 0;
  logic [31:0] e_hf = '0, e_mm = '0;
  logic [3:0]  e_req = '0;

  always #(PERIOD/2) clk = ~clk;

  fault_classifier u_fault_classifier (
    .clk(clk), .rst_n(rst_n),
    .vec_bus_err(ev[0]), .if_prot_err(ev[1]), .dat_prot_err(ev[2]), .stk_prot_err(ev[3]),
    .if_bus_err(ev[4]), .dat_bus_err(ev[5]), .undef_instr(ev[6]), .bad_state(ev[7]),
    .mm_en(cfg[0]), .mm_act(cfg[1]), .bus_en(cfg[2]), .bus_act(cfg[3]),
    .use_en(cfg[4]), .use_act(cfg[5]),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .req_hard(req_hard), .req_mem(req_mem), .req_bus(req_bus), .req_usage(req_usage)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_req(input logic [7:0] e, input logic [5:0] c);
    logic mm, bu, us, fm, fb, fu, hard, gm, gb, gu;
    mm = |e[3:1]; bu = |e[5:4]; us = |e[7:6];
    fm = mm & (!c[0] | c[1]); fb = bu & (!c[2] | c[3]); fu = us & (!c[4] | c[5]);
    hard = e[0] | fm | fb | fu;
    gm = mm & !fm; gb = bu & !fb; gu = us & !fu;
    if (hard) return 4'b0001;
    if (gm)   return 4'b0010;
    if (gb)   return 4'b0100;
    if (gu)   return 4'b1000;
    return 4'b0000;
  endfunction

  function automatic logic forced_of(input logic [7:0] e, input logic [5:0] c);
    return (|e[3:1] & (!c[0] | c[1])) | (|e[5:4] & (!c[2] | c[3])) | (|e[7:6] & (!c[4] | c[5]));
  endfunction

  task automatic read_both(output logic [31:0] hf, output logic [31:0] mm);
    reg_wr = 1'b0;
    reg_sel = 1'b0; #1 hf = reg_rdata;
    reg_sel = 1'b1; #1 mm = reg_rdata;
  endtask

  task automatic cyc(input logic [7:0] e, input logic [5:0] c, input logic s,
                     input logic w, input logic [31:0] d, input string tag);
    logic [31:0] hf, mm;
    ev = e; cfg = c; reg_sel = s; reg_wr = w; reg_wdata = d;
    if (w && !s) e_hf = e_hf & ~(d & 32'h4000_0002);
    if (w &&  s) e_mm = e_mm & ~(d & 32'h0000_0013);
    e_hf = e_hf | (e[0] ? 32'h2 : 0) | (forced_of(e, c) ? 32'h4000_0000 : 0);
    e_mm = e_mm | (e[1] ? 32'h1 : 0) | (e[2] ? 32'h2 : 0) | (e[3] ? 32'h10 : 0);
    e_req = model_req(e, c);
    @(negedge clk);
    ev = '0; reg_wr = 1'b0;
    check({tag, " R8 request"}, {28'd0, req_usage, req_bus, req_mem, req_hard}, {28'd0, e_req});
    read_both(hf, mm);
    check({tag, " R1 R5 R6 R7 hard word"}, hf, e_hf);
    check({tag, " R2 R3 R4 R7 mm word"}, mm, e_mm);
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] hf, mm;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_both(hf, mm);
    check("R9 reset hard word", hf, 0);
    check("R9 reset mm word", mm, 0);
    check("R9 reset requests", {req_hard, req_mem, req_bus, req_usage}, 0);

    cyc(8'h01, 6'b010101, 0, 0, 0, "R1 vector error");
    cyc(8'h02, 6'b010101, 0, 0, 0, "R2 fetch mismatch");
    cyc(8'h04, 6'b010101, 0, 0, 0, "R3 data mismatch");
    cyc(8'h08, 6'b010101, 0, 0, 0, "R4 stacking mismatch");
    cyc(8'h00, 6'b010101, 1, 1, 32'h0, "R7 zero write");
    cyc(8'h00, 6'b010101, 0, 1, 32'hFFFF_FFFF, "R7 other word write");
    cyc(8'h02, 6'b010100, 0, 0, 0, "R5 mm disabled");
    cyc(8'h04, 6'b010111, 0, 0, 0, "R5 mm active");
    cyc(8'h10, 6'b010101, 0, 0, 0, "R6 bus fetch");
    cyc(8'h20, 6'b010001, 0, 0, 0, "R6 bus disabled");
    cyc(8'h40, 6'b010101, 0, 0, 0, "R6 undefined");
    cyc(8'h80, 6'b110101, 0, 0, 0, "R6 usage active");
    cyc(8'hF0, 6'b010101, 0, 0, 0, "R8 bus over usage");
    cyc(8'hFE, 6'b010101, 0, 0, 0, "R8 mm over bus");
    cyc(8'hFF, 6'b010101, 0, 0, 0, "R8 all at once");
    cyc(8'h02, 6'b010101, 1, 1, 32'hFFFF_FFFF, "R7 set wins over clear");
    cyc(8'h00, 6'b010101, 1, 1, 32'hFFFF_FFFF, "R7 clear mm");
    cyc(8'h00, 6'b010101, 0, 1, 32'hFFFF_FFFF, "R7 clear hard");

    for (int i = 0; i < 2000; i++) begin
      logic [7:0] e;
      logic [5:0] c;
      for (int b = 0; b < 8; b++) e[b] = ($urandom_range(0, 9) == 0);
      c = 6'b010101;
      if ($urandom_range(0, 5) == 0) c = 6'($urandom);
      cyc(e, c, 1'($urandom), ($urandom_range(0, 3) == 0), $urandom, "random");
    end

    cyc(8'hFF, 6'b101010, 0, 0, 0, "R5 all escalated");
    read_both(hf, mm);
    check("R10 hard reserved", hf & ~32'h4000_0002, 0);
    check("R10 mm reserved", mm & ~32'h0000_0013, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule